// File: doc/BRIEF.md
# Banked Register and Bit-Address Mapper

This block sits in the internal data path of a small 8-bit controller. It owns 128 bytes of general RAM, the program status register and the stack pointer. Each request arrives in one of three forms: a working-register number, a direct byte address, or a bit address. The block turns the request into one physical byte address, a flag that says whether that address lies in special-register space, and a bit index.

It then carries out the request in the same cycle. A request can read a byte, write a byte, or set, clear, write or read a single bit. A bit update is a read-modify-write of the containing byte, done as one operation.

The working-register window moves through four banks of eight bytes. Two bits of the status register pick the bank. Bit 0 of the status register is not stored. It always shows the parity of the accumulator value supplied on an input.

Top module: `dmap_top`

## Requirements
- R1: After reset the status register reads 00h while the accumulator input is 00h, the stack pointer (byte address 81h) reads 07h, and every RAM byte reads 00h.
- R2: Request kind 00 (register) with register number n = addr[2:0] resolves to byte address bank*8 + n. Here bank = status bits [4:3], so bank 0 covers 00h–07h and bank 3 covers 18h–1Fh.
- R3: A register request uses the bank bits held when it is issued. A write to the status register (direct address D0h) moves the register window from the very next request on.
- R4: Request kind 01 (direct) uses addr as the byte address. Addresses 00h–7Fh hit RAM with the special-register select output low. Addresses 80h–FFh drive the select output high.
- R5: Request kind 10 (bit) with addr < 80h resolves to byte 20h + addr[6:3] with bit index addr[2:0].
- R6: A bit request with addr >= 80h resolves to special-register byte {addr[7:3], 000} with bit index addr[2:0]. For example, bit address D5h is status bit 5.
- R7: On a bit request, op 10 sets the selected bit, op 11 clears it and op 01 writes wdata[0] into it. Each is completed by one request, and the other seven bits of the byte keep their values.
- R8: Status bit 0 equals the XOR of the eight accumulator input bits, which makes the overall parity even. Writing bit 0, by byte or by bit, has no effect.
- R9: For op 00 (read), the byte at the resolved address appears on the read-data output one clock after the request, and the selected bit appears on the read-bit output. The read-valid output is high in that cycle only.
- R10: Ops 10 and 11 on register or direct requests write nothing. A write to a special-register address other than D0h or 81h is dropped, and such addresses read 00h.
- R11: The stack pointer at direct address 81h can be written and read back as a full byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_i | input | 8 | Accumulator value used for the parity flag |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 00 register, 01 direct, 10 bit, 11 no access |
| req_op_i | input | 2 | 00 read, 01 write, 10 bit set, 11 bit clear |
| req_addr_i | input | 8 | Register number, byte address or bit address |
| req_wdata_i | input | 8 | Write byte; bit 0 is the value for a bit write |
| phys_addr_o | output | 8 | Resolved byte address of the current request |
| sfr_sel_o | output | 1 | Resolved address is in special-register space |
| bit_idx_o | output | 3 | Resolved bit index |
| rd_data_o | output | 8 | Byte returned by the last read |
| rd_bit_o | output | 1 | Selected bit returned by the last read |
| rd_valid_o | output | 1 | Read results valid this cycle |
| psw_o | output | 8 | Current status register view, parity included |

## Verification
The bench steps the bank bits through all four values. After each change it checks that the very next register request lands in the new window, so a design that latched the bank late would write the old bank. Bit operations are run on a byte with a mixed pattern, at index 0, index 7 and an inner bit, which catches a wrong mask or a byte write that clobbers neighbours. Bit addresses on both sides of 80h confirm the fold onto 20h–2Fh versus the special-register alignment; an off-by-one shift would hit the wrong byte. Writes to the parity bit, set/clear ops on byte requests, and writes to an unheld special register are each followed by a read-back, so a design that stored any of them would show a changed value.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
    localparam int DW = 8;
    localparam int IW = $clog2(DW);

    typedef enum logic [1:0] {
        K_REG  = 2'b00,
        K_DIR  = 2'b01,
        K_BIT  = 2'b10,
        K_NONE = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_SET = 2'b10,
        OP_CLR = 2'b11
    } op_e;

    typedef struct packed {
        logic [DW-1:0] byte_addr;
        logic [IW-1:0] bit_idx;
        logic          sfr;
        logic          hit;
    } xlate_t;
endpackage

// File: rtl/dmap_decode.sv
module dmap_decode
    import dmap_pkg::*;
#(
    parameter int            REG_AW   = 3,
    parameter int            RS_W     = 2,
    parameter logic [DW-1:0] BIT_BASE = 8'h20
) (
    input  kind_e          kind_i,
    input  logic [DW-1:0]  addr_i,
    input  logic [RS_W-1:0] rs_i,
    output xlate_t         xl_o
);
    localparam int BIT_ROW_W = DW - 1 - IW;

    logic [DW-1:0] reg_byte;
    logic [DW-1:0] low_bit_byte;
    logic [DW-1:0] high_bit_byte;

    always_comb begin
        reg_byte      = DW'({rs_i, addr_i[REG_AW-1:0]});
        low_bit_byte  = BIT_BASE + DW'(addr_i[DW-2 -: BIT_ROW_W]);
        high_bit_byte = {addr_i[DW-1:IW], {IW{1'b0}}};

        xl_o           = '0;
        xl_o.hit       = (kind_i != K_NONE);
        xl_o.bit_idx   = addr_i[IW-1:0];
        unique case (kind_i)
            K_REG:   xl_o.byte_addr = reg_byte;
            K_DIR:   xl_o.byte_addr = addr_i;
            K_BIT:   xl_o.byte_addr = addr_i[DW-1] ? high_bit_byte : low_bit_byte;
            default: xl_o.byte_addr = '0;
        endcase
        xl_o.sfr = xl_o.hit && xl_o.byte_addr[DW-1];
    end
endmodule

// File: rtl/dmap_store.sv
module dmap_store
    import dmap_pkg::*;
#(
    parameter int            RAM_DEPTH = 128,
    parameter logic [DW-1:0] PSW_ADDR  = 8'hD0,
    parameter logic [DW-1:0] SP_ADDR   = 8'h81,
    parameter logic [DW-1:0] SP_RESET  = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] acc_i,
    input  logic          valid_i,
    input  kind_e         kind_i,
    input  op_e           op_i,
    input  xlate_t        xl_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] psw_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_bit_o,
    output logic          rd_valid_o
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);

    typedef struct packed {
        logic [RAM_DEPTH-1:0][DW-1:0] ram;
        logic [DW-1:1]                psw;
        logic [DW-1:0]                sp;
        logic [DW-1:0]                rd_data;
        logic                         rd_bit;
        logic                         rd_valid;
    } state_t;

    state_t s_d, s_q;

    logic [DW-1:0]     psw_view;
    logic [DW-1:0]     cur;
    logic [DW-1:0]     mask;
    logic [DW-1:0]     new_byte;
    logic [RAM_AW-1:0] ram_idx;
    logic              is_bit, act, rd_req, wr_any, ram_we, psw_we, sp_we;

    always_comb begin
        psw_view = {s_q.psw, ^acc_i};
        ram_idx  = xl_i.byte_addr[RAM_AW-1:0];
        is_bit   = (kind_i == K_BIT);
        act      = valid_i && xl_i.hit;
        mask     = DW'(1) << xl_i.bit_idx;

        if (!xl_i.sfr)                        cur = s_q.ram[ram_idx];
        else if (xl_i.byte_addr == PSW_ADDR)  cur = psw_view;
        else if (xl_i.byte_addr == SP_ADDR)   cur = s_q.sp;
        else                                  cur = '0;

        new_byte = cur;
        wr_any   = 1'b0;
        unique case (op_i)
            OP_WR: begin
                new_byte = is_bit ? ((cur & ~mask) | (wdata_i[0] ? mask : '0)) : wdata_i;
                wr_any   = 1'b1;
            end
            OP_SET: begin
                new_byte = cur | mask;
                wr_any   = is_bit;
            end
            OP_CLR: begin
                new_byte = cur & ~mask;
                wr_any   = is_bit;
            end
            default: ;
        endcase

        rd_req = act && (op_i == OP_RD);
        ram_we = act && wr_any && !xl_i.sfr;
        psw_we = act && wr_any && xl_i.sfr && (xl_i.byte_addr == PSW_ADDR);
        sp_we  = act && wr_any && xl_i.sfr && (xl_i.byte_addr == SP_ADDR);

        s_d          = s_q;
        s_d.rd_valid = rd_req;
        if (rd_req) begin
            s_d.rd_data = cur;
            s_d.rd_bit  = cur[xl_i.bit_idx];
        end
        if (ram_we) s_d.ram[ram_idx] = new_byte;
        if (psw_we) s_d.psw = new_byte[DW-1:1];
        if (sp_we)  s_d.sp  = new_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.sp <= SP_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign psw_o      = psw_view;
    assign rd_data_o  = s_q.rd_data;
    assign rd_bit_o   = s_q.rd_bit;
    assign rd_valid_o = s_q.rd_valid;

    a_r7_neighbours_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && is_bit) |=>
        (((s_q.ram[$past(ram_idx)] ^ $past(cur)) & ~$past(mask)) == '0));

    a_r10_ram_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we |=> $stable(s_q.ram));

    a_r8_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !psw_we |=> $stable(s_q.psw));

    a_r9_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid_o);

    a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid_o);
endmodule

// File: rtl/dmap_top.sv
module dmap_top
    import dmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] acc_i,
    input  logic       req_valid_i,
    input  logic [1:0] req_kind_i,
    input  logic [1:0] req_op_i,
    input  logic [7:0] req_addr_i,
    input  logic [7:0] req_wdata_i,
    output logic [7:0] phys_addr_o,
    output logic       sfr_sel_o,
    output logic [2:0] bit_idx_o,
    output logic [7:0] rd_data_o,
    output logic       rd_bit_o,
    output logic       rd_valid_o,
    output logic [7:0] psw_o
);
    localparam int RS_W  = 2;
    localparam int RS_LO = 3;

    kind_e  kind;
    op_e    op;
    xlate_t xl;

    assign kind = kind_e'(req_kind_i);
    assign op   = op_e'(req_op_i);

    dmap_decode #(
        .REG_AW  (3),
        .RS_W    (RS_W),
        .BIT_BASE(8'h20)
    ) u_decode (
        .kind_i(kind),
        .addr_i(req_addr_i),
        .rs_i  (psw_o[RS_LO +: RS_W]),
        .xl_o  (xl)
    );

    dmap_store #(
        .RAM_DEPTH(128),
        .PSW_ADDR (8'hD0),
        .SP_ADDR  (8'h81),
        .SP_RESET (8'h07)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (acc_i),
        .valid_i   (req_valid_i),
        .kind_i    (kind),
        .op_i      (op),
        .xl_i      (xl),
        .wdata_i   (req_wdata_i),
        .psw_o     (psw_o),
        .rd_data_o (rd_data_o),
        .rd_bit_o  (rd_bit_o),
        .rd_valid_o(rd_valid_o)
    );

    assign phys_addr_o = xl.byte_addr;
    assign sfr_sel_o   = xl.sfr;
    assign bit_idx_o   = xl.bit_idx;

    a_r2_bank_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind == K_REG) |->
        (phys_addr_o[7:5] == 3'b000 && phys_addr_o[4:3] == psw_o[4:3] && !sfr_sel_o));

    a_r5_bit_region: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind == K_BIT && !req_addr_i[7]) |->
        (phys_addr_o[7:4] == 4'h2 && bit_idx_o == req_addr_i[2:0]));

    a_r6_sfr_bit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind == K_BIT && req_addr_i[7]) |->
        (sfr_sel_o && phys_addr_o[2:0] == 3'b000));

    a_r4_direct_select: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && kind == K_DIR) |-> (sfr_sel_o == req_addr_i[7]));
endmodule

// File: tb/dmap_top_tb_top.sv
module dmap_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc = 8'h00;
    logic       valid = 1'b0;
    logic [1:0] kind = 2'b11;
    logic [1:0] op = 2'b00;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] phys;
    logic       sfr;
    logic [2:0] bidx;
    logic [7:0] rd_data;
    logic       rd_bit;
    logic       rd_valid;
    logic [7:0] psw;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] c_phys;
    logic       c_sfr;
    logic [2:0] c_idx;

    always #5 clk = ~clk;

    dmap_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_i(acc),
        .req_valid_i(valid), .req_kind_i(kind), .req_op_i(op),
        .req_addr_i(addr), .req_wdata_i(wdata),
        .phys_addr_o(phys), .sfr_sel_o(sfr), .bit_idx_o(bidx),
        .rd_data_o(rd_data), .rd_bit_o(rd_bit), .rd_valid_o(rd_valid),
        .psw_o(psw)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [1:0] o,
                         input logic [7:0] a, input logic [7:0] wd);
        @(negedge clk);
        kind = k; op = o; addr = a; wdata = wd; valid = 1'b1;
        #1;
        c_phys = phys; c_sfr = sfr; c_idx = bidx;
        @(posedge clk);
        #1;
        valid = 1'b0; kind = 2'b11;
    endtask

    task automatic rd_direct(input logic [7:0] a, output logic [7:0] v);
        issue(2'b01, 2'b00, a, 8'h00);
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_direct(8'hD0, v); chk("R1 status after reset", v, 8'h00);
        rd_direct(8'h81, v); chk("R1 stack pointer after reset", v, 8'h07);
        rd_direct(8'h05, v); chk("R1 ram after reset", v, 8'h00);
        rd_direct(8'h7F, v); chk("R1 top ram after reset", v, 8'h00);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        for (int b = 0; b < 4; b++) begin
            issue(2'b01, 2'b01, 8'hD0, 8'(b << 3));
            issue(2'b00, 2'b01, 8'h03, 8'hA0 + 8'(b));
            chk("R3 next request uses new bank", c_phys, 32'(b * 8 + 3));
            rd_direct(8'(b * 8 + 3), v);
            chk("R2 register lands in bank", v, 8'hA0 + 8'(b));
        end
        issue(2'b00, 2'b00, 8'h07, 8'h00);
        chk("R2 bank3 r7 address", c_phys, 8'h1F);
        issue(2'b01, 2'b01, 8'hD0, 8'h00);
        issue(2'b00, 2'b00, 8'h03, 8'h00);
        chk("R2 back to bank0", rd_data, 8'hA0);
    endtask

    task automatic t_direct();
        logic [7:0] v;
        issue(2'b01, 2'b01, 8'h7F, 8'h5A);
        chk("R4 ram select low", c_sfr, 1'b0);
        rd_direct(8'h7F, v); chk("R4 ram readback", v, 8'h5A);
        issue(2'b01, 2'b00, 8'h80, 8'h00);
        chk("R4 sfr select high", c_sfr, 1'b1);
        chk("R4 sfr address passes", c_phys, 8'h80);
    endtask

    task automatic t_bits();
        logic [7:0] v;
        issue(2'b01, 2'b01, 8'h25, 8'hF0);
        issue(2'b10, 2'b11, 8'h2C, 8'h00);
        chk("R5 bit maps to byte", c_phys, 8'h25);
        chk("R5 bit index", c_idx, 3'd4);
        rd_direct(8'h25, v); chk("R7 clear inner bit", v, 8'hE0);
        issue(2'b10, 2'b10, 8'h28, 8'h00);
        rd_direct(8'h25, v); chk("R7 set bit 0", v, 8'hE1);
        issue(2'b10, 2'b01, 8'h2F, 8'h00);
        rd_direct(8'h25, v); chk("R7 write bit 7 to 0", v, 8'h61);
        issue(2'b10, 2'b01, 8'h2A, 8'h01);
        rd_direct(8'h25, v); chk("R7 write bit 2 to 1", v, 8'h65);
        issue(2'b10, 2'b00, 8'h2D, 8'h00);
        chk("R9 read bit 5", rd_bit, 1'b1);
        chk("R9 read valid", rd_valid, 1'b1);
        @(posedge clk); #1;
        chk("R9 valid lasts one cycle", rd_valid, 1'b0);
        issue(2'b10, 2'b00, 8'h7F, 8'h00);
        chk("R5 last bit address", c_phys, 8'h2F);
    endtask

    task automatic t_sfr_bits();
        logic [7:0] v;
        issue(2'b10, 2'b10, 8'hD5, 8'h00);
        chk("R6 sfr bit byte", c_phys, 8'hD0);
        chk("R6 sfr bit select", c_sfr, 1'b1);
        chk("R6 status bit 5 set", psw, 8'h20);
        issue(2'b10, 2'b10, 8'hD0, 8'h00);
        chk("R8 parity bit set ignored", psw, 8'h20);
        issue(2'b10, 2'b11, 8'hD5, 8'h00);
        rd_direct(8'hD0, v); chk("R6 status bit 5 cleared", v, 8'h00);
    endtask

    task automatic t_parity();
        logic [7:0] v;
        acc = 8'h07; #1;
        chk("R8 odd ones gives 1", psw[0], 1'b1);
        acc = 8'h03; #1;
        chk("R8 even ones gives 0", psw[0], 1'b0);
        acc = 8'h00;
        issue(2'b01, 2'b01, 8'hD0, 8'h01);
        rd_direct(8'hD0, v); chk("R8 byte write to P ignored", v, 8'h00);
        acc = 8'h80;
        rd_direct(8'hD0, v); chk("R8 read shows parity", v, 8'h01);
        acc = 8'h00;
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        issue(2'b01, 2'b01, 8'h40, 8'h33);
        issue(2'b01, 2'b10, 8'h40, 8'hFF);
        issue(2'b01, 2'b11, 8'h40, 8'hFF);
        rd_direct(8'h40, v); chk("R10 set/clear on byte ignored", v, 8'h33);
        issue(2'b00, 2'b10, 8'h02, 8'hFF);
        rd_direct(8'h02, v); chk("R10 set on register ignored", v, 8'h00);
        issue(2'b01, 2'b01, 8'h90, 8'hC3);
        rd_direct(8'h90, v); chk("R10 unheld sfr reads zero", v, 8'h00);
    endtask

    task automatic t_sp();
        logic [7:0] v;
        issue(2'b01, 2'b01, 8'h81, 8'h3C);
        rd_direct(8'h81, v); chk("R11 stack pointer readback", v, 8'h3C);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        t_banks();
        t_direct();
        t_bits();
        t_sfr_bits();
        t_parity();
        t_ignored();
        t_sp();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule